// File: doc/BRIEF.md
# Multiplexed GPIO Port with Serial-Receive Routing

This block is an 8-bit general-purpose I/O port. Four memory-mapped registers control it: an output latch, a direction mask that is set bit by bit, and two function-control masks. A simple synchronous bus with write and read strobes and a 2-bit address reaches all four registers. A read of the latch address returns the live pin level for input bits and the latch value for output bits. For bits 1 and up, a set bit in the first function mask replaces the latch with an alternate-function output from a neighbouring controller.

Bit 0 has more uses than the other bits. It can be a plain pin. It can be the clock of a synchronous serial channel, either driving the channel's clock out or passing an external clock in. It can also be the receive input of an infrared link. Bit 0 of the second function mask chooses the serial receiver's data source. With the bit clear, the source is the port-C bit-1 pin. With the bit set, the source is the bit-0 pin after an optional inversion, and bit 0 of the output latch controls that inversion. The serial and infrared controllers are outside this block and appear only as signal ports.

Register addresses: 0 is the latch (read: the pin/latch mix), 1 is direction, 2 is function mask A, 3 is function mask B. Read data is registered and qualified by `rd_valid`. There is no back-pressure. A read strobe always gives data one cycle later.

Top module: `gpio_mux_port`

## Requirements
- R1: While reset is asserted and after it, with no write yet: latch = 0xFF, direction = 0x00, function mask A = 0x00, function mask B = 0x00, and every `pin_oe` bit is 0.
- R2: A write strobe stores `wr_data` into the register at `addr` (0 latch, 1 direction, 2 mask A, 3 mask B) at the next clock edge. A read of addresses 1 to 3 returns the stored value.
- R3: A read of address 0 returns, bit by bit, the latch value where the direction bit is 1 and the `pin_in` level where it is 0.
- R4: A bit whose mask-A bit is 0 drives its latch value on `pin_out`, and its `pin_oe` equals its direction bit.
- R5: For bits 1 to 7, a set mask-A bit drives `alt_out` of that bit on `pin_out`, and `pin_oe` still equals the direction bit.
- R6: Bit 0 in serial-clock output mode (mask A bit 0 = 1, mask B bit 0 = 0, direction bit 0 = 1) drives `sclk_out` on `pin_out[0]` with `pin_oe[0]` = 1.
- R7: Bit 0 in serial-clock input mode (mask A bit 0 = 1, mask B bit 0 = 0, direction bit 0 = 0) has `pin_oe[0]` = 0 and `sclk_ext` = `pin_in[0]`. In every other mode `sclk_ext` = 0.
- R8: Bit 0 in infrared-receive mode (mask A bit 0 = 1, mask B bit 0 = 1) keeps `pin_oe[0]` = 0, whatever the direction bit holds.
- R9: With mask B bit 0 = 0, `rx_data` = `portc1_in`. With it set, `rx_data` = `pin_in[0]` when latch bit 0 is 0 and the inverse of `pin_in[0]` when latch bit 0 is 1.
- R10: `rd_data` and `rd_valid` update one cycle after `rd_en`. `rd_data` holds its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | High one cycle after a read strobe |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| alt_out | input | 7 | Alternate-function outputs for bits 1 to 7 |
| sclk_out | input | 1 | Serial clock from the serial controller |
| sclk_ext | output | 1 | External serial clock to the serial controller |
| portc1_in | input | 1 | Port-C bit-1 pin level |
| rx_data | output | 1 | Serial receiver data input |

## Verification
The assertions run on every cycle and check four things:
- a direction write lands in the register on the next edge;
- read data stays stable between reads;
- bit 0 never drives the pad in infrared mode, and it drives the serial clock in clock-output mode;
- `rx_data` follows `portc1_in` while mask B bit 0 is clear.

Only the bench scenarios show the reset values, the read mix over several direction patterns, and the four combinations of source select and inversion on `rx_data`.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_LATCH = 2'd0;
  localparam logic [ADDR_W-1:0] A_DIR   = 2'd1;
  localparam logic [ADDR_W-1:0] A_FNA   = 2'd2;
  localparam logic [ADDR_W-1:0] A_FNB   = 2'd3;

  typedef enum logic [1:0] {
    B0_GPIO     = 2'd0,
    B0_SCLK_OUT = 2'd1,
    B0_SCLK_IN  = 2'd2,
    B0_IR_RX    = 2'd3
  } b0_mode_e;
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_mux_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  latch_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  fna_q,
  output logic [WIDTH-1:0]  fnb_q,
  output logic [WIDTH-1:0]  rd_data,
  output logic              rd_valid
);
  logic [WIDTH-1:0] rd_mux;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '1;
      dir_q   <= '0;
      fna_q   <= '0;
      fnb_q   <= '0;
    end else if (wr_en) begin
      case (addr)
        A_LATCH: latch_q <= wr_data;
        A_DIR:   dir_q   <= wr_data;
        A_FNA:   fna_q   <= wr_data;
        default: fnb_q   <= wr_data;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_LATCH: rd_mux = (dir_q & latch_q) | (~dir_q & pin_in);
      A_DIR:   rd_mux = dir_q;
      A_FNA:   rd_mux = fna_q;
      default: rd_mux = fnb_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

  // R2: a direction write is visible on the following edge
  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DIR) |=> (dir_q == $past(wr_data)));

  // R10: read data holds without a read strobe
  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/gpio_bit0_mux.sv
module gpio_bit0_mux
  import gpio_mux_pkg::*;
(
  input  logic latch0,
  input  logic dir0,
  input  logic fna0,
  input  logic fnb0,
  input  logic pin_in0,
  input  logic sclk_out,
  input  logic portc1_in,
  output logic pin_out0,
  output logic pin_oe0,
  output logic sclk_ext,
  output logic rx_data
);
  b0_mode_e mode;
  logic     ir_sig;

  always_comb begin
    if (!fna0)     mode = B0_GPIO;
    else if (fnb0) mode = B0_IR_RX;
    else if (dir0) mode = B0_SCLK_OUT;
    else           mode = B0_SCLK_IN;
  end

  always_comb begin
    pin_out0 = latch0;
    pin_oe0  = 1'b0;
    sclk_ext = 1'b0;
    case (mode)
      B0_GPIO:     pin_oe0 = dir0;
      B0_SCLK_OUT: begin pin_out0 = sclk_out; pin_oe0 = 1'b1; end
      B0_SCLK_IN:  sclk_ext = pin_in0;
      default:     pin_oe0 = 1'b0;
    endcase
  end

  assign ir_sig  = pin_in0 ^ latch0;
  assign rx_data = fnb0 ? ir_sig : portc1_in;
endmodule

// File: rtl/gpio_upper_mux.sv
module gpio_upper_mux #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:1] latch_q,
  input  logic [WIDTH-1:1] dir_q,
  input  logic [WIDTH-1:1] fna_q,
  input  logic [WIDTH-1:1] alt_out,
  output logic [WIDTH-1:1] pin_out,
  output logic [WIDTH-1:1] pin_oe
);
  for (genvar i = 1; i < WIDTH; i++) begin : g_bit
    assign pin_out[i] = fna_q[i] ? alt_out[i] : latch_q[i];
    assign pin_oe[i]  = dir_q[i];
  end
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_mux_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wr_data,
  output logic [WIDTH-1:0]  rd_data,
  output logic              rd_valid,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  input  logic [WIDTH-1:1]  alt_out,
  input  logic              sclk_out,
  output logic              sclk_ext,
  input  logic              portc1_in,
  output logic              rx_data
);
  logic [WIDTH-1:0] latch_q, dir_q, fna_q, fnb_q;

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .pin_in(pin_in), .latch_q(latch_q), .dir_q(dir_q),
    .fna_q(fna_q), .fnb_q(fnb_q), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  gpio_bit0_mux u_bit0 (
    .latch0(latch_q[0]), .dir0(dir_q[0]), .fna0(fna_q[0]), .fnb0(fnb_q[0]),
    .pin_in0(pin_in[0]), .sclk_out(sclk_out), .portc1_in(portc1_in),
    .pin_out0(pin_out[0]), .pin_oe0(pin_oe[0]), .sclk_ext(sclk_ext),
    .rx_data(rx_data)
  );

  gpio_upper_mux #(.WIDTH(WIDTH)) u_upper (
    .latch_q(latch_q[WIDTH-1:1]), .dir_q(dir_q[WIDTH-1:1]),
    .fna_q(fna_q[WIDTH-1:1]), .alt_out(alt_out),
    .pin_out(pin_out[WIDTH-1:1]), .pin_oe(pin_oe[WIDTH-1:1])
  );

  // R8: infrared receive mode never drives the pad
  assert_ir_no_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fna_q[0] && fnb_q[0]) |-> !pin_oe[0]);

  // R6: serial clock output mode drives the clock on the pad
  assert_sclk_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fna_q[0] && !fnb_q[0] && dir_q[0]) |-> (pin_oe[0] && pin_out[0] == sclk_out));

  // R9: with the source select clear the receiver follows port C bit 1
  assert_rx_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !fnb_q[0] |-> (rx_data == portc1_in));
endmodule

// File: tb/tb_gpio_mux_port.sv
module tb_gpio_mux_port;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]   addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic         rd_valid;
  logic [W-1:0] pin_in = 8'h3C;
  logic [W-1:0] pin_out, pin_oe;
  logic [W-1:1] alt_out = '0;
  logic         sclk_out = 1'b0, sclk_ext, portc1_in = 1'b0, rx_data;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct { string req; logic [W-1:0] val; } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_mux_port dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .alt_out(alt_out),
    .sclk_out(sclk_out), .sclk_ext(sclk_ext), .portc1_in(portc1_in),
    .rx_data(rx_data)
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [1:0] a, logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: push the expected read value, then issue the read
  task automatic do_read(logic [1:0] a, logic [W-1:0] exp, string req);
    @(negedge clk);
    exp_q.push_back('{req, exp});
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // monitor: compare each returned read against the scoreboard
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check("R10 unexpected rd_valid", 8'h01, 8'h00);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.req, rd_data, e.val);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] hold;
    repeat (3) @(negedge clk);
    check("R1 pin_oe in reset", pin_oe, 8'h00);
    check("R1 pin_out in reset", pin_out, 8'hFF);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pin_oe after reset", pin_oe, 8'h00);
    do_read(2'd0, 8'h3C, "R1 data read as inputs");
    do_read(2'd1, 8'h00, "R1 direction reset");
    do_read(2'd2, 8'h00, "R1 mask A reset");
    do_read(2'd3, 8'h00, "R1 mask B reset");
    do_write(2'd1, 8'hFF);
    do_read(2'd0, 8'hFF, "R1 latch reset all ones");

    // R2: register write/readback
    do_write(2'd2, 8'h5A); do_read(2'd2, 8'h5A, "R2 mask A readback");
    do_write(2'd3, 8'hC3); do_read(2'd3, 8'hC3, "R2 mask B readback");
    do_write(2'd2, 8'h00); do_write(2'd3, 8'h00);

    // R3 and R4 across direction patterns
    do_write(2'd0, 8'hA5);
    foreach (pin_in[k]) begin end
    for (int p = 0; p < 4; p++) begin
      logic [W-1:0] d;
      d = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : (p == 2) ? 8'h0F : 8'h5A;
      do_write(2'd1, d);
      pin_in = 8'h3C ^ d;
      #1;
      check("R4 pin_oe follows direction", pin_oe, d);
      check("R4 pin_out follows latch", pin_out, 8'hA5);
      do_read(2'd0, (d & 8'hA5) | (~d & (8'h3C ^ d)), "R3 pin/latch readback mix");
    end

    // R5: alternate outputs on bits 1..7
    alt_out = 7'b1011001;
    do_write(2'd1, 8'hF0);
    do_write(2'd2, 8'hFE);
    #1;
    check("R5 alt on pin_out", pin_out, {alt_out, 1'b1});
    check("R5 pin_oe keeps direction", pin_oe, 8'hF0);
    do_write(2'd2, 8'h00);

    // R6: serial clock output
    do_write(2'd1, 8'h01);
    do_write(2'd2, 8'h01);
    sclk_out = 1'b0; #1;
    check("R6 sclk drive low", {6'd0, pin_oe[0], pin_out[0]}, 8'h02);
    sclk_out = 1'b1; #1;
    check("R6 sclk drive high", {6'd0, pin_oe[0], pin_out[0]}, 8'h03);
    check("R7 sclk_ext zero in output mode", {7'd0, sclk_ext}, 8'h00);

    // R7: serial clock input
    do_write(2'd1, 8'h00);
    pin_in[0] = 1'b1; #1;
    check("R7 sclk_ext follows pin high", {7'd0, sclk_ext}, 8'h01);
    check("R7 no drive in clock input", {7'd0, pin_oe[0]}, 8'h00);
    pin_in[0] = 1'b0; #1;
    check("R7 sclk_ext follows pin low", {7'd0, sclk_ext}, 8'h00);

    // R8 and R9: infrared receive with inversion
    do_write(2'd3, 8'h01);
    do_write(2'd1, 8'h01);
    #1;
    check("R8 no drive in infrared mode", {7'd0, pin_oe[0]}, 8'h00);
    for (int c = 0; c < 8; c++) begin
      logic inv, pv, cv;
      inv = c[2]; pv = c[1]; cv = c[0];
      do_write(2'd0, {7'h52, inv});
      pin_in[0] = pv; portc1_in = cv; #1;
      check("R9 ir source with invert", {7'd0, rx_data}, {7'd0, pv ^ inv});
    end
    do_write(2'd3, 8'h00);
    for (int c = 0; c < 4; c++) begin
      pin_in[0] = c[1]; portc1_in = c[0]; #1;
      check("R9 port C source", {7'd0, rx_data}, {7'd0, c[0]});
    end

    // R10: read data holds between reads
    do_read(2'd2, 8'h01, "R10 read before idle");
    hold = rd_data;
    repeat (3) @(negedge clk);
    check("R10 rd_data holds", rd_data, hold);
    check("R10 rd_valid low when idle", {7'd0, rd_valid}, 8'h00);
    check("R10 scoreboard drained", 8'(exp_q.size()), 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule